// File: doc/BRIEF.md
# Radix-4 Four-Path Delay Commutator

This block reorders data between two butterfly stages of a pipelined, decimation-in-frequency radix-4 FFT that runs four parallel paths. On every clock it accepts one word: four complex samples, one per path. Three of the paths are held back by different multiples of a base delay. The four paths then pass through a rotating switch built from four 4-to-1 multiplexers. Finally the outputs are held back again in the opposite order, so that the four operands the next butterfly needs arrive on the same clock.

The FFT stage index sets the base delay D = 4^(STAGE-1) words. It also decides which two bits of a shared 6-bit word counter drive the switch. A `sync` pulse marks word 0 of a frame. It restarts the counter and the output-valid timing. Each delay line is a shift register (no reset, so it can map to shift-register or RAM storage) that ends in one ordinary flip-flop. The outputs are registered.

Top module: `mdc_commutator`

## Requirements
- R1: Reset clears `dout_re`, `dout_im` and `dout_vld` to zero. After reset, `dout_vld` stays 0 until a `sync` pulse has been taken.
- R2: The word index n is 0 on a clock edge where `sync` is 1. On any other edge it is the previous index plus one, modulo 64. It is held at 0 while in reset.
- R3: The switch select at edge m is s(m) = bits [2·STAGE-1 : 2·STAGE-2] of the word index n(m). This equals floor(n/D) mod 4, with D = 4^(STAGE-1) and STAGE in 1..3.
- R4: Input path i (path i occupies bits [W·i +: W] of each data bus) reaches the switch delayed by i·D words. Path 0 is not delayed.
- R5: At edge m, switch output j takes switch input (j + s(m)) mod 4. The four outputs always form a permutation of the four inputs.
- R6: Output path j leaves the switch through a (3-j)·D word delay and then an output register. After edge k it therefore holds x_p(m - p·D), where m = k - (3-j)·D and p = (j + s(m)) mod 4.
- R7: `dout_vld` becomes 1 after the edge that comes 3·D+1 edges after the edge that took `sync`. It then stays 1 until the next `sync` or reset.
- R8: A `sync` clears `dout_vld` on the next edge and restarts the 3·D+1 count. Back-to-back `sync` pulses keep `dout_vld` low.
- R9: The real and imaginary parts of each path follow identical routes and delays. They are never swapped or mixed with those of another path.
- R10: R2 to R9 hold for each stage setting 1, 2 and 3, that is for D = 1, 4 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one parallel word per edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Marks the current word as index 0 of a frame |
| din_re | input | 4·DATA_W | Real parts of the four input paths, path i at [DATA_W·i +: DATA_W] |
| din_im | input | 4·DATA_W | Imaginary parts of the four input paths |
| dout_re | output | 4·DATA_W | Real parts of the four reordered output paths |
| dout_im | output | 4·DATA_W | Imaginary parts of the four reordered output paths |
| dout_vld | output | 1 | Output group timing valid |

## Verification
A delay line of the wrong length puts values from the wrong word on one output path. This shows up within 6·D+1 edges of the first fully populated window, and it keeps showing on every word after that. A select drawn from the wrong counter bits, or a rotation in the wrong direction, mixes the path order. That is visible inside one select period of 4·D words. A counter that does not restart on `sync` is visible at the first resynchronisation. A wrong fill count moves the rising edge of `dout_vld` by whole edges against the expected 3·D+1.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  localparam int unsigned NPATH   = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned WCNT_W  = 6;
  localparam int unsigned STAGE_MAX = WCNT_W / SEL_W;

  // base delay in words for a given stage (4^(stage-1))
  function automatic int unsigned base_delay(input int unsigned stage);
    return 1 << (SEL_W * (stage - 1));
  endfunction

  // pipeline distance from sync edge to the first valid output group
  function automatic int unsigned fill_latency(input int unsigned stage);
    return (NPATH - 1) * base_delay(stage) + 1;
  endfunction

endpackage

// File: rtl/mdc_delay_line.sv
module mdc_delay_line #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned LEN   = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (LEN == 0) begin : g_wire
      assign dout = din;
    end else if (LEN == 1) begin : g_single
      logic [WIDTH-1:0] tail_q;
      always_ff @(posedge clk) begin
        tail_q <= din;
      end
      assign dout = tail_q;
    end else begin : g_chain
      localparam int unsigned SRL_LEN = LEN - 1;
      // storage without reset so it can map to shift-register or RAM cells
      logic [WIDTH-1:0] chain_q [SRL_LEN];
      logic [WIDTH-1:0] tail_q;
      always_ff @(posedge clk) begin
        chain_q[0] <= din;
        for (int unsigned t = 1; t < SRL_LEN; t++) begin
          chain_q[t] <= chain_q[t-1];
        end
        tail_q <= chain_q[SRL_LEN-1];
      end
      assign dout = tail_q;
    end
  endgenerate

endmodule

// File: rtl/mdc_sel_ctrl.sv
module mdc_sel_ctrl
  import mdc_pkg::*;
#(
  parameter int unsigned STAGE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  output logic [SEL_W-1:0] sel,
  output logic             vld
);

  localparam int unsigned LAT    = fill_latency(STAGE);
  localparam int unsigned FILL_W = $clog2(LAT + 1);
  localparam int unsigned SEL_LO = SEL_W * (STAGE - 1);

  logic [WCNT_W-1:0] cnt_q;
  logic [WCNT_W-1:0] word_idx;
  logic [FILL_W-1:0] fill_q;
  logic              armed_q;
  logic              vld_q;

  assign word_idx = sync ? '0 : cnt_q;
  assign sel      = word_idx[SEL_LO +: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= word_idx + WCNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (sync) begin
      fill_q  <= '0;
      armed_q <= 1'b1;
      vld_q   <= 1'b0;
    end else if (armed_q && fill_q == FILL_W'(LAT - 1)) begin
      vld_q   <= 1'b1;
    end else if (armed_q) begin
      fill_q  <= fill_q + FILL_W'(1);
    end
  end

  assign vld = vld_q;

  // R2: sync restarts the word index, so the next stored count is 1
  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (rst)
    sync |=> cnt_q == WCNT_W'(1));

  // R2: without sync the count advances by one per word
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    !sync |=> cnt_q == $past(cnt_q) + WCNT_W'(1));

  // R8: a sync drops the valid flag on the following edge
  assert_sync_drops_vld_R8: assert property (@(posedge clk) disable iff (rst)
    sync |=> !vld);

  // R7: once valid, stays valid until a sync arrives
  assert_vld_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (vld && !sync) |=> vld);

  // R7: valid can only rise after the fill count reached its end
  assert_vld_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(vld) |-> $past(fill_q) == FILL_W'(LAT - 1));

endmodule

// File: rtl/mdc_rotator.sv
module mdc_rotator
  import mdc_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic [NPATH*WIDTH-1:0] a,
  input  logic [SEL_W-1:0]       sel,
  output logic [NPATH*WIDTH-1:0] b
);

  logic [NPATH-1:0] route [NPATH];

  generate
    for (genvar j = 0; j < NPATH; j++) begin : g_out
      logic [SEL_W-1:0] src;
      assign src = SEL_W'(j) + sel;
      always_comb begin
        route[j] = '0;
        route[j][src] = 1'b1;
        case (src)
          2'd0:    b[j*WIDTH +: WIDTH] = a[0*WIDTH +: WIDTH];
          2'd1:    b[j*WIDTH +: WIDTH] = a[1*WIDTH +: WIDTH];
          2'd2:    b[j*WIDTH +: WIDTH] = a[2*WIDTH +: WIDTH];
          default: b[j*WIDTH +: WIDTH] = a[3*WIDTH +: WIDTH];
        endcase
      end
    end
  endgenerate

  // R5: every output picks exactly one source and all sources are used once
  always_comb begin
    assert_route_perm_R5: assert ((route[0] | route[1] | route[2] | route[3]) == 4'hF &&
                                  $onehot(route[0]) && $onehot(route[1]) &&
                                  $onehot(route[2]) && $onehot(route[3]));
  end

endmodule

// File: rtl/mdc_commutator.sv
module mdc_commutator
  import mdc_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned STAGE  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sync,
  input  logic [NPATH*DATA_W-1:0] din_re,
  input  logic [NPATH*DATA_W-1:0] din_im,
  output logic [NPATH*DATA_W-1:0] dout_re,
  output logic [NPATH*DATA_W-1:0] dout_im,
  output logic                    dout_vld
);

  localparam int unsigned D   = base_delay(STAGE);
  localparam int unsigned CW  = 2 * DATA_W;

  logic [NPATH*CW-1:0] pre_sw;
  logic [NPATH*CW-1:0] post_sw;
  logic [NPATH*CW-1:0] post_dly;
  logic [SEL_W-1:0]    sel;
  logic                vld;
  logic [NPATH*DATA_W-1:0] out_re_q;
  logic [NPATH*DATA_W-1:0] out_im_q;
  logic                vld_q;

  mdc_sel_ctrl #(.STAGE(STAGE)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .sync (sync),
    .sel  (sel),
    .vld  (vld)
  );

  generate
    for (genvar i = 0; i < NPATH; i++) begin : g_in
      mdc_delay_line #(.WIDTH(CW), .LEN(i * D)) u_dly_in (
        .clk  (clk),
        .din  ({din_im[i*DATA_W +: DATA_W], din_re[i*DATA_W +: DATA_W]}),
        .dout (pre_sw[i*CW +: CW])
      );
    end
  endgenerate

  mdc_rotator #(.WIDTH(CW)) u_rot (
    .a   (pre_sw),
    .sel (sel),
    .b   (post_sw)
  );

  generate
    for (genvar j = 0; j < NPATH; j++) begin : g_out
      mdc_delay_line #(.WIDTH(CW), .LEN((NPATH - 1 - j) * D)) u_dly_out (
        .clk  (clk),
        .din  (post_sw[j*CW +: CW]),
        .dout (post_dly[j*CW +: CW])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          out_re_q[j*DATA_W +: DATA_W] <= '0;
          out_im_q[j*DATA_W +: DATA_W] <= '0;
        end else begin
          out_re_q[j*DATA_W +: DATA_W] <= post_dly[j*CW +: DATA_W];
          out_im_q[j*DATA_W +: DATA_W] <= post_dly[j*CW + DATA_W +: DATA_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld;
  end

  // valid of the control stage is already registered; align to data register
  assign dout_re  = out_re_q;
  assign dout_im  = out_im_q;
  assign dout_vld = vld;

  // R1: outputs are cleared on the edge after reset is seen
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dout_re == '0 && dout_im == '0 && !dout_vld));

  // R7: the valid flag never falls without a sync or reset on the previous edge
  assert_vld_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !dout_vld) |-> $past(sync));

endmodule

// File: tb/mdc_commutator_tb.sv
module mdc_commutator_tb;

  localparam int unsigned W    = 12;
  localparam int unsigned HMSK = 127;
  localparam int unsigned NCYC = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync = 1'b0;
  logic [4*W-1:0] din_re = '0;
  logic [4*W-1:0] din_im = '0;

  logic [4*W-1:0] o_re [3];
  logic [4*W-1:0] o_im [3];
  logic           o_vld [3];

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] hre [4][128];
  logic [W-1:0] him [4][128];
  int           nh  [128];
  int           last_sync = -1;

  always #2 clk = ~clk;

  mdc_commutator #(.DATA_W(W), .STAGE(2)) u_dut (
    .clk(clk), .rst(rst), .sync(sync), .din_re(din_re), .din_im(din_im),
    .dout_re(o_re[1]), .dout_im(o_im[1]), .dout_vld(o_vld[1]));

  mdc_commutator #(.DATA_W(W), .STAGE(1)) u_dut_s1 (
    .clk(clk), .rst(rst), .sync(sync), .din_re(din_re), .din_im(din_im),
    .dout_re(o_re[0]), .dout_im(o_im[0]), .dout_vld(o_vld[0]));

  mdc_commutator #(.DATA_W(W), .STAGE(3)) u_dut_s3 (
    .clk(clk), .rst(rst), .sync(sync), .din_re(din_re), .din_im(din_im),
    .dout_re(o_re[2]), .dout_im(o_im[2]), .dout_vld(o_vld[2]));

  function automatic logic [W-1:0] exp_val(int stg, int j, int k, bit imag);
    int d, m, s, p, src;
    d = 1 << (2 * (stg - 1));
    m = k - (3 - j) * d;
    s = (nh[m & HMSK] >> (2 * (stg - 1))) & 3;
    p = (j + s) % 4;
    src = (m - p * d) & HMSK;
    return imag ? him[p][src] : hre[p][src];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic check_edge(int k);
    for (int x = 0; x < 3; x++) begin
      int stg = x + 1;
      int d = 1 << (2 * x);
      bit ev = (last_sync >= 0) && (k - last_sync >= 3 * d + 1);
      chk(o_vld[x] == ev, $sformatf("R7 R8 R10 stage=%0d vld", stg), o_vld[x], ev);
      if (o_vld[x] && k >= 6 * d) begin
        for (int j = 0; j < 4; j++) begin
          logic [W-1:0] er = exp_val(stg, j, k, 1'b0);
          logic [W-1:0] ei = exp_val(stg, j, k, 1'b1);
          // R2 R3 R4 R5 R6: routing and delay of real part
          chk(o_re[x][j*W +: W] == er,
              $sformatf("R2 R3 R4 R5 R6 R10 stage=%0d path=%0d re", stg, j),
              o_re[x][j*W +: W], er);
          // R9: imaginary part follows the same route
          chk(o_im[x][j*W +: W] == ei,
              $sformatf("R9 R10 stage=%0d path=%0d im", stg, j),
              o_im[x][j*W +: W], ei);
        end
      end
    end
  endtask

  task automatic drive_edge(int k, int prev_n);
    bit sy;
    logic [W-1:0] vr, vi;
    sy = 1'b0;
    if (k == 0 || k == 300) sy = 1'b1;
    else if (k >= 600 && k < 1800) sy = ($urandom % 150) == 0;
    else if (k >= 1800 && k < 1805) sy = 1'b1;
    else if (k == 2400) sy = 1'b1;
    sync = sy;
    for (int i = 0; i < 4; i++) begin
      if (k < 600) begin
        vr = W'(4 * k + i);
        vi = ~vr;
      end else if (k >= 2500 && k < 2600) begin
        vr = (k[0] ^ i[0]) ? '1 : '0;
        vi = ~vr;
      end else begin
        vr = W'($urandom);
        vi = W'($urandom);
      end
      din_re[i*W +: W] = vr;
      din_im[i*W +: W] = vi;
      hre[i][k & HMSK] = vr;
      him[i][k & HMSK] = vi;
    end
    nh[k & HMSK] = sy ? 0 : (prev_n + 1) % 64;
    if (sy) last_sync = k;
  endtask

  task automatic finish_up();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state of every instance
    for (int x = 0; x < 3; x++) begin
      chk(o_re[x] == '0 && o_im[x] == '0, "R1 data", o_re[x], 0);
      chk(o_vld[x] == 1'b0, "R1 vld", o_vld[x], 0);
    end
    drive_edge(0, 63);
    rst = 1'b0;
    for (int k = 0; k < NCYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(k);
      drive_edge(k + 1, nh[k & HMSK]);
    end
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      finish_up();
    end
  end

endmodule